// File: doc/BRIEF.md
# Line-Lock Phase Detector Gate Controller

This block decides, line by line, when the phase detector of a horizontal line-locking loop may compare phases, how fast the loop reacts, and whether the loop is closed at all. A line strobe comes from the loop's own oscillator. It leads the expected horizontal sync by a fixed number of reference-clock cycles. Each gate window is centred on that expected sync position. Outside the window the phase detector is blanked, so copy-protection pulses in the field blanking and disturbances from overmodulated subtitles near the bottom of the picture cannot pull the loop.

The window width depends on the signal state. The block uses a wide window during vertical retrace and a medium window in a configurable band of lower picture lines. The medium window is used only when the line count per frame is standard. When noise is present, a narrow window is used on every line. Outside these cases the detector runs ungated. The noise flag selects a slow loop time constant, and a register bit can override that choice. In fast mode during retrace, a boost flag asks for 50% more detector current. A video-present flag opens or closes the loop for internally sourced composite video, unless a register bit decouples it. All decisions are sampled only at the line strobe, so no gate pulse is ever cut short.

Top module: `line_pd_gate_ctrl`

## Requirements
- R1: After reset, and until the first line strobe, pd_gate=1, tc_slow=0, pd_boost=0 and loop_closed=1.
- R2: Line position p counts reference cycles since the line strobe, and the cycle after the strobe edge is p=0. In a retrace line, pd_gate is 1 exactly for p in [SYNC_POS-W/2, SYNC_POS-W/2+W-1], with W = 22 µs in cycles (220*CLK_KHZ/10000).
- R3: Line number n is the count of line strobes since the last frame strobe, and the first line after the frame strobe is n=1. In a line with n in [LOW_FIRST, LOW_LAST], std_lines=1, no noise and no retrace, pd_gate uses the same window rule with W = 120*CLK_KHZ/10000.
- R4: In the lower band with std_lines=0, and in any line without noise, retrace or lower-band gating, pd_gate stays 1 for the whole line.
- R5: With noise_flag=1, every line is gated with W = 57*CLK_KHZ/10000. Noise takes priority over retrace, and retrace takes priority over the lower band.
- R6: Without override, tc_slow equals noise_flag.
- R7: With tc_force_en=1, tc_slow equals tc_force_slow whatever the noise state.
- R8: pd_boost is 1 exactly when the line's time constant is fast and retrace was active.
- R9: With int_composite=1 and vid_decouple=0, loop_closed equals video_present. Otherwise loop_closed=1.
- R10: Every input is sampled only at a line strobe. Changes in the middle of a line have no effect on any output until the next strobe.
- R11: A frame strobe restarts the line count, so the next line strobe gives n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 1 | One-cycle line strobe from the loop oscillator |
| frame_stb | input | 1 | One-cycle vertical sync strobe |
| retrace | input | 1 | Vertical retrace period active |
| std_lines | input | 1 | Line count per frame is standard (625 or 525) |
| noise_flag | input | 1 | Noise detector reports a weak signal |
| video_present | input | 1 | Video identification result |
| tc_force_en | input | 1 | Register bit: override automatic time-constant choice |
| tc_force_slow | input | 1 | Register bit: forced mode is slow (1) or fast (0) |
| int_composite | input | 1 | Composite video source is internal |
| vid_decouple | input | 1 | Register bit: detach video identification from the loop |
| pd_gate | output | 1 | Phase detector enable |
| tc_slow | output | 1 | Loop time constant slow (1) or fast (0) |
| pd_boost | output | 1 | Raise detector current by half |
| loop_closed | output | 1 | Loop closed (1) or open (0) |

## Verification
The line-rate outputs tc_slow, pd_boost and loop_closed change at the clock edge that samples the strobe. They are checked at the falling edge that follows, and again at the end of the line. pd_gate depends only on registered state. The bench therefore samples it at each falling edge after the strobe edge, and the k-th sample is line position p=k. Right after each strobe the bench inverts every control input, so any output that reacted before the next strobe would show up as a mismatch.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic [1:0] {
    GM_OPEN    = 2'd0,
    GM_RETRACE = 2'd1,
    GM_LOWER   = 2'd2,
    GM_NOISE   = 2'd3
  } gate_mode_e;

  // Duration in tenths of a microsecond to reference-clock cycles.
  function automatic int tenths_to_cycles(int tenths, int clk_khz);
    return (tenths * clk_khz) / 10000;
  endfunction

  // First position of a window of the given width centred on centre.
  function automatic int win_lo(int centre, int width);
    return centre - width / 2;
  endfunction

  function automatic logic in_window(int pos, int centre, int width);
    return (pos >= win_lo(centre, width)) && (pos < win_lo(centre, width) + width);
  endfunction

  function automatic gate_mode_e pick_mode(logic noisy, logic vret, logic low_std);
    if (noisy)        return GM_NOISE;
    else if (vret)    return GM_RETRACE;
    else if (low_std) return GM_LOWER;
    else              return GM_OPEN;
  endfunction

endpackage

// File: rtl/lpg_line_timer.sv
module lpg_line_timer #(
  parameter int POS_W     = 11,
  parameter int LINE_W    = 10,
  parameter int LOW_FIRST = 260,
  parameter int LOW_LAST  = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              frame_stb,
  output logic [POS_W-1:0]  pos,
  output logic [LINE_W-1:0] line_cnt,
  output logic              lower_nxt
);

  localparam logic [LINE_W-1:0] LF   = LINE_W'(LOW_FIRST);
  localparam logic [LINE_W-1:0] LL   = LINE_W'(LOW_LAST);
  localparam logic [LINE_W-1:0] LMAX = '1;
  localparam logic [POS_W-1:0]  PMAX = '1;

  logic [LINE_W-1:0] line_nxt;

  always_comb begin
    if (frame_stb)
      line_nxt = '0;
    else if (line_stb && line_cnt != LMAX)
      line_nxt = line_cnt + 1'b1;
    else
      line_nxt = line_cnt;
  end

  assign lower_nxt = (line_nxt >= LF) && (line_nxt <= LL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      line_cnt <= '0;
    end else begin
      line_cnt <= line_nxt;
      if (line_stb)
        pos <= '0;
      else if (pos != PMAX)
        pos <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/lpg_mode_sel.sv
module lpg_mode_sel
  import lpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       noise_flag,
  input  logic       retrace,
  input  logic       std_lines,
  input  logic       lower_nxt,
  input  logic       tc_force_en,
  input  logic       tc_force_slow,
  input  logic       video_present,
  input  logic       int_composite,
  input  logic       vid_decouple,
  output gate_mode_e mode,
  output logic       tc_slow,
  output logic       pd_boost,
  output logic       loop_closed
);

  logic vret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= GM_OPEN;
      tc_slow     <= 1'b0;
      vret_q      <= 1'b0;
      loop_closed <= 1'b1;
    end else if (line_stb) begin
      mode        <= pick_mode(noise_flag, retrace, lower_nxt && std_lines);
      tc_slow     <= tc_force_en ? tc_force_slow : noise_flag;
      vret_q      <= retrace;
      loop_closed <= (int_composite && !vid_decouple) ? video_present : 1'b1;
    end
  end

  assign pd_boost = !tc_slow && vret_q;

endmodule

// File: rtl/line_pd_gate_ctrl.sv
module line_pd_gate_ctrl #(
  parameter int CLK_KHZ   = 27000,
  parameter int SYNC_POS  = 600,
  parameter int POS_W     = 11,
  parameter int LINE_W    = 10,
  parameter int LOW_FIRST = 260,
  parameter int LOW_LAST  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic frame_stb,
  input  logic retrace,
  input  logic std_lines,
  input  logic noise_flag,
  input  logic video_present,
  input  logic tc_force_en,
  input  logic tc_force_slow,
  input  logic int_composite,
  input  logic vid_decouple,
  output logic pd_gate,
  output logic tc_slow,
  output logic pd_boost,
  output logic loop_closed
);
  import lpg_pkg::*;

  localparam int RETRACE_W = tenths_to_cycles(220, CLK_KHZ);
  localparam int LOWER_W   = tenths_to_cycles(120, CLK_KHZ);
  localparam int NOISE_W   = tenths_to_cycles(57, CLK_KHZ);

  logic [POS_W-1:0]  pos;
  logic [LINE_W-1:0] line_cnt;
  logic              lower_nxt;
  gate_mode_e        mode;

  lpg_line_timer #(
    .POS_W(POS_W), .LINE_W(LINE_W), .LOW_FIRST(LOW_FIRST), .LOW_LAST(LOW_LAST)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
    .pos(pos), .line_cnt(line_cnt), .lower_nxt(lower_nxt)
  );

  lpg_mode_sel u_mode (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
    .noise_flag(noise_flag), .retrace(retrace), .std_lines(std_lines),
    .lower_nxt(lower_nxt), .tc_force_en(tc_force_en), .tc_force_slow(tc_force_slow),
    .video_present(video_present), .int_composite(int_composite),
    .vid_decouple(vid_decouple), .mode(mode), .tc_slow(tc_slow),
    .pd_boost(pd_boost), .loop_closed(loop_closed)
  );

  always_comb begin
    unique case (mode)
      GM_RETRACE: pd_gate = in_window(int'(pos), SYNC_POS, RETRACE_W);
      GM_LOWER:   pd_gate = in_window(int'(pos), SYNC_POS, LOWER_W);
      GM_NOISE:   pd_gate = in_window(int'(pos), SYNC_POS, NOISE_W);
      default:    pd_gate = 1'b1;
    endcase
  end

endmodule

// File: rtl/lpg_checker.sv
module lpg_checker
  import lpg_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_stb,
  input logic              frame_stb,
  input logic              tc_force_en,
  input logic              tc_force_slow,
  input logic              int_composite,
  input logic              vid_decouple,
  input logic              video_present,
  input logic              pd_gate,
  input logic              tc_slow,
  input logic              pd_boost,
  input logic              loop_closed,
  input gate_mode_e        mode,
  input logic [LINE_W-1:0] line_cnt
);

  assert_open_ungated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GM_OPEN) |-> pd_gate);

  assert_force_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_stb) && $past(tc_force_en)) |-> (tc_slow == $past(tc_force_slow)));

  assert_boost_fast_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_boost |-> !tc_slow);

  assert_loop_follows_video_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_stb) && $past(int_composite) && !$past(vid_decouple))
      |-> (loop_closed == $past(video_present)));

  assert_hold_midline_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_stb) |-> ($stable(tc_slow) && $stable(loop_closed) && $stable(mode)));

  assert_frame_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_stb) |-> (line_cnt == '0));

endmodule

bind line_pd_gate_ctrl lpg_checker #(.LINE_W(LINE_W)) u_lpg_checker (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
  .tc_force_en(tc_force_en), .tc_force_slow(tc_force_slow),
  .int_composite(int_composite), .vid_decouple(vid_decouple),
  .video_present(video_present), .pd_gate(pd_gate), .tc_slow(tc_slow),
  .pd_boost(pd_boost), .loop_closed(loop_closed), .mode(mode), .line_cnt(line_cnt)
);

// File: tb/test_line_pd_gate_ctrl.sv
`timescale 1ns/1ps
module test_line_pd_gate_ctrl;

  localparam int CLK_KHZ   = 1000;
  localparam int SYNC_POS  = 16;
  localparam int LOW_FIRST = 6;
  localparam int LOW_LAST  = 8;
  localparam int LINE_LEN  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, frame_stb = 1'b0, retrace = 1'b0, std_lines = 1'b0;
  logic noise_flag = 1'b0, video_present = 1'b0, tc_force_en = 1'b0, tc_force_slow = 1'b0;
  logic int_composite = 1'b0, vid_decouple = 1'b0;
  logic pd_gate, tc_slow, pd_boost, loop_closed;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int bline = 0;

  always #2 clk = ~clk;

  line_pd_gate_ctrl #(
    .CLK_KHZ(CLK_KHZ), .SYNC_POS(SYNC_POS), .POS_W(6), .LINE_W(5),
    .LOW_FIRST(LOW_FIRST), .LOW_LAST(LOW_LAST)
  ) i_line_pd_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
    .retrace(retrace), .std_lines(std_lines), .noise_flag(noise_flag),
    .video_present(video_present), .tc_force_en(tc_force_en),
    .tc_force_slow(tc_force_slow), .int_composite(int_composite),
    .vid_decouple(vid_decouple), .pd_gate(pd_gate), .tc_slow(tc_slow),
    .pd_boost(pd_boost), .loop_closed(loop_closed)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (line %0d)", req, act, exp, bline);
    end
  endtask

  // Expected gate: window width from microseconds, centred on SYNC_POS.
  function automatic logic exp_gate(int width_tenths, int p);
    int w, lo;
    if (width_tenths == 0) return 1'b1;
    w  = width_tenths * CLK_KHZ / 10000;
    lo = SYNC_POS - w / 2;
    return (p >= lo) && (p <= lo + w - 1);
  endfunction

  task automatic run_line(logic [7:0] c);
    logic n, v, s, fe, fs, vp, ic, dc, lower, e_slow, e_boost, e_loop;
    int wt;
    string greq;
    {dc, ic, vp, fs, fe, s, v, n} = c;
    bline++;
    lower = (bline >= LOW_FIRST) && (bline <= LOW_LAST);
    if (n)               begin wt = 57;  greq = "R5"; end
    else if (v)          begin wt = 220; greq = "R2"; end
    else if (lower && s) begin wt = 120; greq = "R3"; end
    else                 begin wt = 0;   greq = "R4"; end
    e_slow  = fe ? fs : n;
    e_boost = !e_slow && v;
    e_loop  = (ic && !dc) ? vp : 1'b1;
    noise_flag = n; retrace = v; std_lines = s; tc_force_en = fe;
    tc_force_slow = fs; video_present = vp; int_composite = ic; vid_decouple = dc;
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
    // R10: flip every control input right after the strobe.
    {vid_decouple, int_composite, video_present, tc_force_slow, tc_force_en,
     std_lines, retrace, noise_flag} = ~c;
    check(fe ? "R7" : "R6", tc_slow, e_slow);
    check("R8", pd_boost, e_boost);
    check("R9", loop_closed, e_loop);
    for (int k = 0; k < LINE_LEN; k++) begin
      check(greq, pd_gate, exp_gate(wt, k));
      @(negedge clk);
    end
    check("R10", tc_slow, e_slow);
    check("R10", pd_boost, e_boost);
    check("R10", loop_closed, e_loop);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", pd_gate, 1'b1);
    check("R1", tc_slow, 1'b0);
    check("R1", pd_boost, 1'b0);
    check("R1", loop_closed, 1'b1);
    for (int c = 0; c < 256; c++) begin
      if (c % 11 == 0) begin
        // R11: frame strobe restarts the line count.
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        bline = 0;
      end
      run_line(8'(c));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule